// File: doc/BRIEF.md
# Banked Expansion-Card ROM and GROM Port Decoder

This block is the bus-facing control logic of a peripheral expansion card. It watches a 16-bit CPU address bus with byte-wide data, a separate bit-serial CRU write path and a physical enable switch. Two write-only control bits, the card-activate bit and the upper-ROM bank bit, are loaded from CRU writes.

When the switch is on and the card is activated, the block decodes the 8 KiB device-service window. The lower 4 KiB of the window maps onto a fixed ROM. The upper 4 KiB maps onto one of two banks of a second ROM. Both ROMs sit in one 12 KiB image.

The block also recognises four card-private GROM port addresses and emits a one-clock strobe for each access. It merges the ready lines of all GROM chips into one. ROM contents and the GROM chips live outside the block: it supplies the ROM address and steers either ROM or GROM read data onto its byte output.

Top module: `card_rom_decoder`

## Requirements
- R1: The card takes part in a CPU access only when `card_sw`=1, the activate bit is 1 and `bus_addr` lies in 0x4000..0x5FFF. Otherwise `bus_drive`=0, `bus_dout`=0xFF, `rom_rd`=0, and no GROM strobe follows.
- R2: A CRU write (`cru_wr`=1) is taken only when `cru_addr[15:8]`=0x1F. Its bit index is {`cru_addr[7]`, `cru_addr[2]`, `cru_addr[1]`}, with `cru_addr[7]` as the MSB, so 0x1F00 is index 0, 0x1F80 is index 4 and 0x1F86 is index 7. The remaining address bits are ignored.
- R3: A taken CRU write to index 0 loads `cru_bit` into the activate bit, and the new value applies from the next cycle.
- R4: A taken CRU write to index 4 loads `cru_bit` into the bank bit. Writes to any other index, including 7, change no state.
- R5: After reset the activate bit and the bank bit are both 0.
- R6: A qualified read with `bus_addr[12]`=0 sets `rom_rd`=1, `rom_addr`={2'b00, `bus_addr[11:0]`} and `bus_dout`=`rom_rdata` in the same cycle.
- R7: A qualified read with `bus_addr[12]`=1 that is not a GROM port read gives `rom_addr`=0x1000+`bus_addr[11:0]` when the bank bit is 0, and 0x2000+`bus_addr[11:0]` when it is 1.
- R8: A qualified read where (`bus_addr` & 0x1FFD)=0x1BFC is a GROM read. `bus_dout`=`grom_rdata` in that cycle and `rom_rd`=0. One cycle later `grom_rd_data` pulses if `bus_addr[1]`=0, or `grom_rd_addr` pulses if it was 1.
- R9: A qualified write where (`bus_addr` & 0x1FFD)=0x1FFC pulses `grom_wr_data` (when `bus_addr[1]`=0) or `grom_wr_addr` (when it is 1) one cycle later. All other writes produce no strobe.
- R10: The GROM strobes are registered. Each is high only in the cycle after the qualifying access cycle, and at most one is high at a time.
- R11: `ready` is 1 only when every bit of `grom_rdy` is 1.
- R12: When `card_sw` is 0, all decoding stops in that same cycle, but the activate and bank bits keep their values and apply again once the switch returns to 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| card_sw | input | 1 | Physical card enable switch |
| bus_addr | input | 16 | CPU address |
| bus_rd | input | 1 | One-cycle read request |
| bus_wr | input | 1 | One-cycle write request |
| cru_addr | input | 16 | CRU bit address |
| cru_wr | input | 1 | CRU write strobe |
| cru_bit | input | 1 | CRU write data bit |
| rom_rdata | input | 8 | Byte returned by the external ROM image |
| grom_rdata | input | 8 | Byte returned by the GROM chips |
| grom_rdy | input | 8 | Per-GROM ready lines |
| bus_dout | output | 8 | Read data toward the CPU, 0xFF when idle |
| bus_drive | output | 1 | Card is supplying read data |
| rom_addr | output | 14 | Byte address into the 12 KiB ROM image |
| rom_rd | output | 1 | ROM read in progress |
| grom_rd_data | output | 1 | GROM data read strobe |
| grom_rd_addr | output | 1 | GROM address read strobe |
| grom_wr_data | output | 1 | GROM data write strobe |
| grom_wr_addr | output | 1 | GROM address write strobe |
| ready | output | 1 | Combined GROM ready |

## Verification
Only two state bits exist. A wrong activate bit shows up on the very next window read: `bus_dout` either sits at 0xFF or carries data when it should not. A wrong bank bit shows up only on the next read of the upper 4 KiB, as a `rom_addr` that is off by exactly 0x1000. The stimulus therefore mixes frequent CRU writes with frequent upper-window reads, so a corrupted bit is exposed within a few cycles. Strobe faults appear one cycle after the access, so every cycle's strobe vector is compared with a prediction carried over from the previous cycle.

// File: rtl/card_rom_decoder.sv
module card_rom_decoder #(
  parameter int DW       = 8,
  parameter int NGROM    = 8,
  parameter int OFS_W    = 12,
  parameter logic [7:0] CRU_PAGE = 8'h1F
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             card_sw,
  input  logic [15:0]      bus_addr,
  input  logic             bus_rd,
  input  logic             bus_wr,
  input  logic [15:0]      cru_addr,
  input  logic             cru_wr,
  input  logic             cru_bit,
  input  logic [DW-1:0]    rom_rdata,
  input  logic [DW-1:0]    grom_rdata,
  input  logic [NGROM-1:0] grom_rdy,
  output logic [DW-1:0]    bus_dout,
  output logic             bus_drive,
  output logic [OFS_W+1:0] rom_addr,
  output logic             rom_rd,
  output logic             grom_rd_data,
  output logic             grom_rd_addr,
  output logic             grom_wr_data,
  output logic             grom_wr_addr,
  output logic             ready
);
  localparam logic [15:0] PORT_MASK = 16'h1FFD;
  localparam logic [15:0] RD_PORT   = 16'h1BFC;
  localparam logic [15:0] WR_PORT   = 16'h1FFC;

  logic act_q, bank_q;

  wire       in_win   = (bus_addr[15:13] == 3'b010);
  wire       live     = card_sw & act_q & in_win;
  wire       rd_port  = ((bus_addr & PORT_MASK) == RD_PORT);
  wire       wr_port  = ((bus_addr & PORT_MASK) == WR_PORT);
  wire       g_rd_hit = live & bus_rd & rd_port;
  wire       g_wr_hit = live & bus_wr & wr_port;
  wire       cru_hit  = cru_wr & (cru_addr[15:8] == CRU_PAGE);
  wire [2:0] cru_idx  = {cru_addr[7], cru_addr[2], cru_addr[1]};
  wire       unused_cru = ^{cru_addr[6:3], cru_addr[0]};

  assign rom_rd    = live & bus_rd & ~rd_port;
  assign bus_drive = rom_rd | g_rd_hit;
  assign bus_dout  = rom_rd ? rom_rdata : (g_rd_hit ? grom_rdata : {DW{1'b1}});
  assign rom_addr  = bus_addr[12] ? {bank_q, ~bank_q, bus_addr[OFS_W-1:0]}
                                  : {2'b00, bus_addr[OFS_W-1:0]};
  assign ready     = &grom_rdy;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      act_q  <= 1'b0;
      bank_q <= 1'b0;
    end else if (cru_hit) begin
      if (cru_idx == 3'd0) act_q  <= cru_bit;
      if (cru_idx == 3'd4) bank_q <= cru_bit;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      grom_rd_data <= 1'b0;
      grom_rd_addr <= 1'b0;
      grom_wr_data <= 1'b0;
      grom_wr_addr <= 1'b0;
    end else begin
      grom_rd_data <= g_rd_hit & ~bus_addr[1];
      grom_rd_addr <= g_rd_hit &  bus_addr[1];
      grom_wr_data <= g_wr_hit & ~bus_addr[1];
      grom_wr_addr <= g_wr_hit &  bus_addr[1];
    end
  end

  a_r10_strobe_onehot: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({grom_rd_data, grom_rd_addr, grom_wr_data, grom_wr_addr}));

  a_r8_rd_strobe_cause: assert property (@(posedge clk) disable iff (!rst_n)
    (grom_rd_data | grom_rd_addr) |-> $past(bus_rd && card_sw && bus_addr[15:13] == 3'b010));

  a_r9_wr_strobe_cause: assert property (@(posedge clk) disable iff (!rst_n)
    (grom_wr_data | grom_wr_addr) |-> $past(bus_wr && card_sw && bus_addr[15:13] == 3'b010));

  a_r4_state_needs_cru: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(cru_wr) |-> ($stable(act_q) && $stable(bank_q)));

  a_r12_switch_off_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    !card_sw |-> (!bus_drive && !rom_rd && bus_dout == {DW{1'b1}}));

  a_r11_ready_low: assert property (@(posedge clk) disable iff (!rst_n)
    ($countones(grom_rdy) != NGROM) |-> !ready);
endmodule

// File: tb/test_card_rom_decoder.sv
module test_card_rom_decoder;
  localparam int PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        card_sw, bus_rd, bus_wr, cru_wr, cru_bit;
  logic [15:0] bus_addr, cru_addr;
  logic [7:0]  rom_rdata, grom_rdata, grom_rdy;
  logic [7:0]  bus_dout;
  logic        bus_drive, rom_rd, ready;
  logic [13:0] rom_addr;
  logic        grom_rd_data, grom_rd_addr, grom_wr_data, grom_wr_addr;

  int n_tests = 0, n_fail = 0;
  logic m_act = 1'b0, m_bank = 1'b0;
  logic [3:0] exp_stb = 4'b0;

  always #(PERIOD/2) clk = ~clk;

  card_rom_decoder i_card_rom_decoder (
    .clk(clk), .rst_n(rst_n), .card_sw(card_sw), .bus_addr(bus_addr),
    .bus_rd(bus_rd), .bus_wr(bus_wr), .cru_addr(cru_addr), .cru_wr(cru_wr),
    .cru_bit(cru_bit), .rom_rdata(rom_rdata), .grom_rdata(grom_rdata),
    .grom_rdy(grom_rdy), .bus_dout(bus_dout), .bus_drive(bus_drive),
    .rom_addr(rom_addr), .rom_rd(rom_rd), .grom_rd_data(grom_rd_data),
    .grom_rd_addr(grom_rd_addr), .grom_wr_data(grom_wr_data),
    .grom_wr_addr(grom_wr_addr), .ready(ready));

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic f_live(input logic [15:0] a);
    return card_sw && m_act && a[15:13] == 3'b010;
  endfunction
  function automatic logic f_rdport(input logic [15:0] a);
    return (a & 16'h1FFD) == 16'h1BFC;
  endfunction
  function automatic logic f_wrport(input logic [15:0] a);
    return (a & 16'h1FFD) == 16'h1FFC;
  endfunction
  function automatic logic [13:0] f_rom(input logic [15:0] a);
    if (!a[12]) return {2'b00, a[11:0]};
    return (m_bank ? 14'h2000 : 14'h1000) + {2'b00, a[11:0]};
  endfunction

  // One bus cycle: strobe check, drive, combinational checks, model update.
  task automatic cyc(input logic sw, input logic rd, input logic wr, input logic [15:0] a,
                     input logic cw, input logic [15:0] ca, input logic cb, input logic [7:0] rdy);
    logic eg, er, ewr;
    @(negedge clk);
    check("R10 strobes", {grom_rd_data, grom_rd_addr, grom_wr_data, grom_wr_addr}, exp_stb);
    card_sw = sw; bus_rd = rd; bus_wr = wr; bus_addr = a;
    cru_wr = cw; cru_addr = ca; cru_bit = cb; grom_rdy = rdy;
    rom_rdata = 8'($urandom); grom_rdata = 8'($urandom);
    #1;
    eg  = rd && f_live(a) && f_rdport(a);
    er  = rd && f_live(a) && !f_rdport(a);
    ewr = wr && f_live(a) && f_wrport(a);
    if (er) begin
      check(a[12] ? "R7 rom_addr" : "R6 rom_addr", rom_addr, f_rom(a));
      check("R6 dout", {bus_drive, rom_rd, bus_dout}, {2'b11, rom_rdata});
    end else if (eg)
      check("R8 dout", {bus_drive, rom_rd, bus_dout}, {2'b10, grom_rdata});
    else
      check(sw ? "R1 idle" : "R12 idle", {bus_drive, rom_rd, bus_dout}, {2'b00, 8'hFF});
    check("R11 ready", ready, &rdy);
    exp_stb = {eg && !a[1], eg && a[1], ewr && !a[1], ewr && a[1]};
    if (cw && ca[15:8] == 8'h1F) begin
      if ({ca[7], ca[2], ca[1]} == 3'd0) m_act  = cb;
      if ({ca[7], ca[2], ca[1]} == 3'd4) m_bank = cb;
    end
  endtask

  initial begin
    #(PERIOD * 200000);
    n_tests++; n_fail++;
    $display("FAIL watchdog actual=running expected=done");
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    logic [15:0] a, ca;
    logic cb;
    void'($urandom(32'd1234));
    rst_n = 1'b0; card_sw = 1'b1; bus_rd = 0; bus_wr = 0; bus_addr = 0;
    cru_wr = 0; cru_addr = 0; cru_bit = 0; rom_rdata = 0; grom_rdata = 0; grom_rdy = 8'hFF;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // R5: after reset the card is inactive, so reads return idle
    cyc(1, 1, 0, 16'h5000, 0, 0, 0, 8'hFF);
    cyc(1, 1, 0, 16'h5BFC, 0, 0, 0, 8'hFF);
    // R3: activate; R7 first bank
    cyc(1, 0, 0, 0, 1, 16'h1F00, 1, 8'hFF);
    cyc(1, 1, 0, 16'h5123, 0, 0, 0, 8'hFF);
    // R2: other page ignored; R4: index 7 ignored, index 4 selects bank
    cyc(1, 0, 0, 0, 1, 16'h1E80, 1, 8'hFF);
    cyc(1, 1, 0, 16'h5FFF, 1, 16'h1F86, 1, 8'hFF);
    cyc(1, 1, 0, 16'h5004, 1, 16'h1F80, 1, 8'hFF);
    cyc(1, 1, 0, 16'h5004, 0, 0, 0, 8'hFF);
    cyc(1, 1, 0, 16'h4ABC, 0, 0, 0, 8'h7F);
    // R8 / R9 ports and an ignored window write
    cyc(1, 1, 0, 16'h5BFE, 0, 0, 0, 8'hFF);
    cyc(1, 0, 1, 16'h5FFC, 0, 0, 0, 8'hFF);
    cyc(1, 0, 1, 16'h5FFE, 0, 0, 0, 8'hFF);
    cyc(1, 0, 1, 16'h5BFC, 0, 0, 0, 8'hFF);
    // R12: switch off blocks at once, state kept on return
    cyc(0, 1, 0, 16'h5010, 0, 0, 0, 8'hFF);
    cyc(0, 0, 1, 16'h5FFE, 0, 0, 0, 8'hFF);
    cyc(1, 1, 0, 16'h5010, 0, 0, 0, 8'hFF);
    for (int i = 0; i < 4000; i++) begin
      case ($urandom % 8)
        0: a = 16'h5BFC | 16'($urandom & 2);
        1: a = 16'h5FFC | 16'($urandom & 2);
        6: a = 16'($urandom);
        default: a = 16'h4000 | 16'($urandom & 16'h1FFF);
      endcase
      ca = ($urandom % 4 == 0) ? 16'($urandom) : (16'h1F00 | 16'($urandom & 16'hFF));
      if ($urandom % 2 == 0) ca = 16'h1F00 | 16'($urandom & 16'h86);
      cb = ({ca[7], ca[2], ca[1]} == 3'd0) ? ($urandom % 4 != 0) : 1'($urandom);
      cyc($urandom % 10 != 0, $urandom % 2 == 0, $urandom % 3 == 0 ? 1'b0 : 1'($urandom),
          a, $urandom % 4 == 0, ca, cb,
          ($urandom % 4 == 0) ? 8'($urandom) : 8'hFF);
    end
    cyc(1, 0, 0, 0, 0, 0, 0, 8'hFF);
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule